// File: doc/BRIEF.md
# Single-Wire Bus Slave Front End

This block is the device-side receiver for a single open-drain data line with a pull-up. It watches the synchronised line level and measures how long each low period lasts. When the line has stayed low for long enough, the block treats this as a bus reset, from any state. After the master releases the line, the block answers with a presence pulse: it asserts an open-drain pull-down enable for a fixed number of ticks.

The block then samples incoming bit slots. It takes one sample a fixed time after each falling edge. It assembles the first byte, least-significant bit first, as a ROM command. A legal ROM command is handed to the device core with a one-cycle strobe. For every legal command except the two search commands, the next byte is handed over as the function command.

Any traffic outside this order is dropped, and the block goes back to waiting for a reset. This covers bytes with no reset before them, an unknown ROM code, bytes after a search command and bytes after the function command. All durations are counted in ticks of `tick_i`, a one-cycle strobe with a nominal period of 1 µs.

Top module: `sw_slave_fe`

## Requirements
- R1: A low period on `line_i` lasting RESET_TICKS ticks (default 480) is a bus reset in every state. It discards any partly received byte and restarts the transaction.
- R2: A presence pulse follows each bus reset. Once the line goes high after the reset, `pull_en_o` rises after about PRES_WAIT ticks (default 30), always within 15 to 60 ticks. It stays high for PRES_LEN ticks (default 120), always within 60 to 240 ticks.
- R3: Each bit is sampled SAMPLE_TICKS ticks (default 30) after a falling edge of the line. A low sample is 0 and a high sample is 1. Bytes are assembled least-significant bit first.
- R4: The first byte after the presence pulse is the ROM command. The legal codes are 8'h33, 8'h55, 8'hCC, 8'hF0 and 8'hEC. A legal code appears on `rom_cmd_o` together with a single-cycle pulse on `rom_stb_o`.
- R5: An unknown ROM code produces no strobe, and the block returns to waiting for reset. The byte that follows gives no `fn_stb_o`.
- R6: After ROM code 8'hF0 or 8'hEC, the block waits for a new reset. The bytes that follow produce no strobe.
- R7: After any other legal ROM code, the next byte appears on `fn_cmd_o` together with a single-cycle pulse on `fn_stb_o`. Later bytes are ignored until the next reset.
- R8: Without a reset, low periods shorter than RESET_TICKS produce no presence pulse and no strobes.
- R9: After `rst_n`, `pull_en_o`, `rom_stb_o` and `fn_stb_o` are low. The block waits for a bus reset and ignores any byte sent before one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe, one tick per nominal microsecond |
| line_i | input | 1 | Synchronised level of the bus line |
| pull_en_o | output | 1 | Pull-down enable for the open-drain driver |
| rom_stb_o | output | 1 | One-cycle pulse: a legal ROM command was received |
| rom_cmd_o | output | 8 | Last legal ROM command |
| fn_stb_o | output | 1 | One-cycle pulse: a function command was received |
| fn_cmd_o | output | 8 | Last function command |

## Verification
A wrong transaction state shows up at the ports within one byte time. It appears as a strobe that should be missing, a missing strobe, or a byte that is shifted or bit-swapped. A stuck or mistimed presence pulse shows up within about 250 ticks of the master releasing the reset, as a wrong delay or width of `pull_en_o`. A reset that fails to clear a partly received byte shows up in the first command after it as a wrong value.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RST_LOW = 3'd1,
    ST_PRES    = 3'd2,
    ST_ROM     = 3'd3,
    ST_FN      = 3'd4
  } fe_state_t;

  function automatic logic rom_is_search(input logic [7:0] code);
    return (code == 8'hF0) || (code == 8'hEC);
  endfunction

  function automatic logic rom_is_valid(input logic [7:0] code);
    return (code == 8'h33) || (code == 8'h55) || (code == 8'hCC) || rom_is_search(code);
  endfunction

endpackage

// File: rtl/sw_low_timer.sv
module sw_low_timer #(
  parameter int RESET_TICKS = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_i,
  output logic reset_hit_o
);
  localparam int CW = $clog2(RESET_TICKS + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (line_i) begin
      low_cnt <= '0;
    end else if (tick_i && low_cnt != CW'(RESET_TICKS)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign reset_hit_o = !line_i && tick_i && (low_cnt == CW'(RESET_TICKS - 1));
endmodule

// File: rtl/sw_presence_gen.sv
module sw_presence_gen #(
  parameter int PRES_WAIT = 30,
  parameter int PRES_LEN  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  input  logic abort_i,
  output logic pull_o,
  output logic done_o
);
  localparam int MAXV = (PRES_WAIT > PRES_LEN) ? PRES_WAIT : PRES_LEN;
  localparam int PW   = $clog2(MAXV + 1);

  typedef enum logic [1:0] {PH_OFF, PH_WAIT, PH_DRIVE} phase_t;

  phase_t        phase;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_OFF;
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        phase <= PH_OFF;
        cnt   <= '0;
      end else if (start_i) begin
        phase <= PH_WAIT;
        cnt   <= '0;
      end else if (tick_i) begin
        case (phase)
          PH_WAIT: begin
            if (cnt == PW'(PRES_WAIT - 1)) begin
              phase <= PH_DRIVE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DRIVE: begin
            if (cnt == PW'(PRES_LEN - 1)) begin
              phase  <= PH_OFF;
              cnt    <= '0;
              done_o <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign pull_o = (phase == PH_DRIVE);
endmodule

// File: rtl/sw_bit_sampler.sv
module sw_bit_sampler #(
  parameter int SAMPLE_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic line_i,
  input  logic fall_i,
  input  logic en_i,
  input  logic abort_i,
  output logic bit_vld_o,
  output logic bit_val_o
);
  localparam int SW = $clog2(SAMPLE_TICKS + 1);

  logic          busy;
  logic [SW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      bit_vld_o <= 1'b0;
      bit_val_o <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (abort_i) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (!busy) begin
        if (fall_i && en_i) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (tick_i) begin
        if (cnt == SW'(SAMPLE_TICKS - 1)) begin
          busy      <= 1'b0;
          bit_vld_o <= 1'b1;
          bit_val_o <= line_i;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sw_slave_fe.sv
module sw_slave_fe #(
  parameter int RESET_TICKS  = 480,
  parameter int PRES_WAIT    = 30,
  parameter int PRES_LEN     = 120,
  parameter int SAMPLE_TICKS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       line_i,
  output logic       pull_en_o,
  output logic       rom_stb_o,
  output logic [7:0] rom_cmd_o,
  output logic       fn_stb_o,
  output logic [7:0] fn_cmd_o
);
  import sw_pkg::*;

  fe_state_t  st;
  logic       line_q;
  logic       fall, rise;
  logic       reset_hit;
  logic       pres_start, pres_done;
  logic       bit_vld, bit_val;
  logic       byte_done;
  logic [7:0] byte_val;
  logic [6:0] byte_sr;
  logic [2:0] bit_idx;
  logic       rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_i;
  end

  assign fall       = line_q && !line_i;
  assign rise       = !line_q && line_i;
  assign rx_en      = (st == ST_ROM) || (st == ST_FN);
  assign pres_start = (st == ST_RST_LOW) && rise && !reset_hit;
  assign byte_val   = {bit_val, byte_sr};
  assign byte_done  = bit_vld && rx_en && (bit_idx == 3'd7);

  sw_low_timer #(.RESET_TICKS(RESET_TICKS)) u_low (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .line_i(line_i),
    .reset_hit_o(reset_hit)
  );

  sw_presence_gen #(.PRES_WAIT(PRES_WAIT), .PRES_LEN(PRES_LEN)) u_pres (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(pres_start),
    .abort_i(reset_hit), .pull_o(pull_en_o), .done_o(pres_done)
  );

  sw_bit_sampler #(.SAMPLE_TICKS(SAMPLE_TICKS)) u_smp (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .line_i(line_i),
    .fall_i(fall), .en_i(rx_en), .abort_i(reset_hit),
    .bit_vld_o(bit_vld), .bit_val_o(bit_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      byte_sr   <= '0;
      bit_idx   <= '0;
      rom_stb_o <= 1'b0;
      rom_cmd_o <= '0;
      fn_stb_o  <= 1'b0;
      fn_cmd_o  <= '0;
    end else begin
      rom_stb_o <= 1'b0;
      fn_stb_o  <= 1'b0;
      if (reset_hit) begin
        st      <= ST_RST_LOW;
        bit_idx <= '0;
      end else begin
        case (st)
          ST_RST_LOW: if (rise) st <= ST_PRES;
          ST_PRES: if (pres_done) begin
            st      <= ST_ROM;
            bit_idx <= '0;
          end
          ST_ROM, ST_FN: if (bit_vld) begin
            byte_sr <= byte_val[7:1];
            bit_idx <= bit_idx + 1'b1;
            if (byte_done) begin
              if (st == ST_FN) begin
                fn_stb_o <= 1'b1;
                fn_cmd_o <= byte_val;
                st       <= ST_IDLE;
              end else if (rom_is_valid(byte_val)) begin
                rom_stb_o <= 1'b1;
                rom_cmd_o <= byte_val;
                st        <= rom_is_search(byte_val) ? ST_IDLE : ST_FN;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sw_slave_fe_chk.sv
module sw_slave_fe_chk (
  input logic              clk,
  input logic              rst_n,
  input sw_pkg::fe_state_t st,
  input logic              reset_hit,
  input logic              byte_done,
  input logic [7:0]        byte_val,
  input logic              pull_en_o,
  input logic              rom_stb_o,
  input logic [7:0]        rom_cmd_o,
  input logic              fn_stb_o
);
  import sw_pkg::*;

  AST_RESET_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> st == ST_RST_LOW); // R1
  AST_PULL_ONLY_PRES: assert property (@(posedge clk) disable iff (!rst_n)
    pull_en_o |-> st == ST_PRES); // R2
  AST_ROM_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rom_stb_o |-> rom_is_valid(rom_cmd_o)); // R4
  AST_ROM_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_stb_o |=> !rom_stb_o); // R4
  AST_BAD_ROM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_ROM && !rom_is_valid(byte_val) && !reset_hit)
      |=> (st == ST_IDLE && !rom_stb_o)); // R5
  AST_SEARCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_stb_o && rom_is_search(rom_cmd_o)) |-> st == ST_IDLE); // R6
  AST_FN_NEEDS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    fn_stb_o |-> $past(st) == ST_FN); // R7
endmodule

bind sw_slave_fe sw_slave_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .reset_hit(reset_hit),
  .byte_done(byte_done), .byte_val(byte_val), .pull_en_o(pull_en_o),
  .rom_stb_o(rom_stb_o), .rom_cmd_o(rom_cmd_o), .fn_stb_o(fn_stb_o)
);

// File: tb/sw_slave_fe_tb.sv
module sw_slave_fe_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic line;
  logic pull_en, rom_stb, fn_stb;
  logic [7:0] rom_cmd, fn_cmd;

  always #10 clk = ~clk;

  assign line = ~(m_low | pull_en);

  sw_slave_fe u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(1'b1), .line_i(line),
    .pull_en_o(pull_en), .rom_stb_o(rom_stb), .rom_cmd_o(rom_cmd),
    .fn_stb_o(fn_stb), .fn_cmd_o(fn_cmd)
  );

  int cyc = 0, n_chk = 0, n_fail = 0;
  int rom_n = 0, fn_n = 0, pres_n = 0, pres_start = 0, pres_len = 0, rel_cyc = 0;
  logic [7:0] rom_last = 8'h00, fn_last = 8'h00;
  logic pull_q = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pull_q <= pull_en;
    if (rom_stb) begin rom_n <= rom_n + 1; rom_last <= rom_cmd; end
    if (fn_stb)  begin fn_n  <= fn_n + 1;  fn_last  <= fn_cmd;  end
    if (pull_en && !pull_q) begin pres_start <= cyc; pres_n <= pres_n + 1; end
    if (!pull_en && pull_q) pres_len <= cyc - pres_start;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_reset(input int low);
    m_low = 1'b1; idle(low);
    m_low = 1'b0; rel_cyc = cyc;
    idle(300);
  endtask

  task automatic wr_bit(input logic b);
    m_low = 1'b1; idle(b ? 6 : 60);
    m_low = 1'b0; idle(b ? 64 : 10);
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
    idle(5);
  endtask

  // {rom code, fn byte, expect rom strobe, expect fn strobe}
  localparam logic [17:0] VEC [0:7] = '{
    {8'h33, 8'h44, 1'b1, 1'b1},
    {8'h55, 8'hBE, 1'b1, 1'b1},
    {8'hCC, 8'h4E, 1'b1, 1'b1},
    {8'hF0, 8'h12, 1'b1, 1'b0},
    {8'hEC, 8'h34, 1'b1, 1'b0},
    {8'hA5, 8'h44, 1'b0, 1'b0},
    {8'h00, 8'hFF, 1'b0, 1'b0},
    {8'hCC, 8'hB8, 1'b1, 1'b1}
  };

  initial begin
    int r0, f0, p0, dly;
    idle(5);
    rst_n = 1'b1;
    idle(3);
    // R9 reset state
    check(pull_en == 1'b0, "R9 pull_en after reset", pull_en, 0);
    check(rom_stb == 1'b0 && fn_stb == 1'b0, "R9 strobes after reset", {rom_stb, fn_stb}, 0);
    wr_byte(8'hCC);
    check(rom_n == 0, "R9 byte before any bus reset", rom_n, 0);

    // R8 short low gives nothing
    m_low = 1'b1; idle(200); m_low = 1'b0; idle(300);
    check(pres_n == 0, "R8 short low no presence", pres_n, 0);

    foreach (VEC[i]) begin
      p0 = pres_n; r0 = rom_n; f0 = fn_n;
      bus_reset(500); // R1
      dly = pres_start - rel_cyc;
      check(pres_n == p0 + 1, "R1 reset detected, presence sent", pres_n - p0, 1);
      check(dly >= 15 && dly <= 60, "R2 presence delay", dly, 31);
      check(pres_len >= 60 && pres_len <= 240, "R2 presence width", pres_len, 120);
      wr_byte(VEC[i][17:10]);
      check(rom_n - r0 == int'(VEC[i][1]), "R4/R5 rom strobe count", rom_n - r0, VEC[i][1]);
      if (VEC[i][1])
        check(rom_last == VEC[i][17:10], "R3/R4 rom code lsb first", rom_last, VEC[i][17:10]);
      wr_byte(VEC[i][9:2]);
      check(fn_n - f0 == int'(VEC[i][0]), "R6/R7 fn strobe count", fn_n - f0, VEC[i][0]);
      if (VEC[i][0])
        check(fn_last == VEC[i][9:2], "R7 fn byte", fn_last, VEC[i][9:2]);
    end

    // R7 bytes after the function byte are ignored
    f0 = fn_n; r0 = rom_n;
    wr_byte(8'h33);
    check(fn_n == f0 && rom_n == r0, "R7 trailing byte ignored", fn_n - f0, 0);

    // R1 reset in mid-byte discards partial bits
    bus_reset(500);
    for (int k = 0; k < 4; k++) wr_bit(1'b1);
    r0 = rom_n; f0 = fn_n;
    bus_reset(500);
    wr_byte(8'hCC);
    wr_byte(8'h44);
    check(rom_n == r0 + 1 && rom_last == 8'hCC, "R1 mid-byte reset rom", rom_last, 8'hCC);
    check(fn_n == f0 + 1 && fn_last == 8'h44, "R1 mid-byte reset fn", fn_last, 8'h44);

    // R6 two bytes after search still silent
    bus_reset(500);
    wr_byte(8'hF0);
    f0 = fn_n; r0 = rom_n;
    wr_byte(8'h33);
    wr_byte(8'h44);
    check(fn_n == f0 && rom_n == r0, "R6 bytes after search", fn_n - f0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule